// File: doc/BRIEF.md
# Flag-Qualified Instruction Decode CAM

This block chooses which row of a reconfigurable array supplies the result of a custom instruction call. Every row keeps a stored instruction ID, loaded through a configuration write port together with a per-row "force qualifier" bit. When a call arrives, all rows compare their stored ID with the called ID in parallel. A row is selected only when the IDs are equal and its qualifier is true. The qualifier is the flag that the row's leftmost cell supplies, unless the row's force bit overrides it. The selected row's data word is placed on the result bus. A registered copy of the word, with a writeback strobe, follows one cycle after the call.

Several rows may hold the same ID. Because each row's flag gates its own match, those rows act together as a distributed output multiplexer: the array logic raises exactly one of their flags. If no row qualifies, the block raises a miss so the host can stall and load a configuration. An ID of all ones is reserved. Rows that are empty, or that sit inside a multirow instruction, hold it, and a call with that ID is rejected rather than looked up. A multi-output function gives each output row a distinct ID and needs one call per output.

Top module: `flag_decode_cam`

## Requirements
- R1: After reset every row holds the reserved all-ones ID with its force bit clear, so no call hits until rows are configured, and `wb_valid` is low.
- R2: Row r matches a valid call only when its stored ID equals `call_id` and `row_flag[r]` is 1; with an equal ID and a 0 flag, that row does not match.
- R3: A row written with `cfg_force_flag`=1 matches on an equal ID whatever its `row_flag` bit is.
- R4: On a hit, `res_bus` equals the selected row's word `row_data[r*DATA_W +: DATA_W]`, with bit i of that word driving result bit i.
- R5: A valid, non-reserved call with no matching row raises `call_miss`, keeps `call_hit` low and drives `res_bus` to zero; at most one of `call_hit`, `call_miss` and `call_reject` is high.
- R6: A valid call whose ID is all ones raises `call_reject` with neither hit nor miss, even if a row stores all ones and has a true qualifier.
- R7: When several rows match, the lowest-numbered matching row drives `res_bus` and `multi_hit` is 1; with a single match `multi_hit` is 0.
- R8: One cycle after a hit, `wb_valid` is 1 and `wb_data` holds the word the bus carried during the call; after any cycle without a hit, `wb_valid` is 0.
- R9: With `call_valid` low, `call_hit`, `call_miss` and `call_reject` are 0 and `res_bus` is zero, whatever the flags are.
- R10: A configuration write replaces only the addressed row's ID and force bit, and takes effect from the next cycle. A call in the same cycle still sees the old contents. Writing all ones unconfigures the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_row | input | $clog2(ROWS) | Row addressed by the write |
| cfg_id | input | ID_W | ID stored into that row |
| cfg_force_flag | input | 1 | Force-qualifier bit stored into that row |
| call_valid | input | 1 | A custom instruction call is present |
| call_id | input | ID_W | Called instruction ID |
| row_flag | input | ROWS | Per-row qualifier from each row's leftmost cell |
| row_data | input | ROWS*DATA_W | Per-row output words, row r at bits r*DATA_W upward |
| res_bus | output | DATA_W | Combinational result bus |
| call_hit | output | 1 | A row qualified for the call |
| call_miss | output | 1 | No row qualified, configuration load needed |
| call_reject | output | 1 | Call used the reserved ID |
| multi_hit | output | 1 | More than one row qualified |
| wb_valid | output | 1 | Registered writeback strobe |
| wb_data | output | DATA_W | Registered writeback word |

## Verification
On every cycle, the checker enforces the following: the outcome flags are mutually exclusive, the block is silent when no call is present, and reserved IDs are rejected. It also checks that the bus is zero whenever there is no hit, that a multi-hit always implies a hit, and that the writeback strobe and word follow the bus by exactly one cycle. Which row is selected, and whether the stored IDs, flags and force bits were honoured, can only be shown by the bench's scenarios. These compare the bus against the word of the row expected to win. They cover shared-ID multiplexing, forced qualifiers, lowest-row priority, same-cycle configuration writes, unconfiguring a row, and a second reset.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_HIT    = 2'd1,
        OUT_MISS   = 2'd2,
        OUT_REJECT = 2'd3
    } outcome_e;

endpackage

// File: rtl/fdc_id_store.sv
module fdc_id_store #(
    parameter int ROWS = 32,
    parameter int ID_W = 8,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ROW_W-1:0]           cfg_row,
    input  logic [ID_W-1:0]            cfg_id,
    input  logic                       cfg_force_flag,
    output logic [ROWS-1:0][ID_W-1:0]  ids_o,
    output logic [ROWS-1:0]            force_o
);

    typedef struct packed {
        logic [ROWS-1:0][ID_W-1:0] ids;
        logic [ROWS-1:0]           frc;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_row) < ROWS)) begin
            st_d.ids[cfg_row] = cfg_id;
            st_d.frc[cfg_row] = cfg_force_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ids <= '1;
            st_q.frc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ids_o   = st_q.ids;
    assign force_o = st_q.frc;

endmodule

// File: rtl/fdc_match.sv
module fdc_match #(
    parameter int ROWS = 32,
    parameter int ID_W = 8
) (
    input  logic                       lookup_en,
    input  logic [ID_W-1:0]            call_id,
    input  logic [ROWS-1:0][ID_W-1:0]  ids,
    input  logic [ROWS-1:0]            force_q,
    input  logic [ROWS-1:0]            row_flag,
    output logic [ROWS-1:0]            hit_vec
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic id_eq;
        logic qual;
        assign id_eq      = (ids[r] == call_id);
        assign qual       = row_flag[r] | force_q[r];
        assign hit_vec[r] = lookup_en & id_eq & qual;
    end

endmodule

// File: rtl/fdc_prio_sel.sv
module fdc_prio_sel #(
    parameter int ROWS   = 32,
    parameter int DATA_W = 32,
    localparam int SEL_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CNT_W = $clog2(ROWS + 1)
) (
    input  logic [ROWS-1:0]          hit_vec,
    input  logic [ROWS*DATA_W-1:0]   row_data,
    output logic                     any_o,
    output logic                     multi_o,
    output logic [DATA_W-1:0]        data_o
);

    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        sel = '0;
        cnt = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (hit_vec[r]) begin
                sel = SEL_W'(r);
            end
            cnt = cnt + CNT_W'(hit_vec[r]);
        end
    end

    assign any_o   = |hit_vec;
    assign multi_o = (cnt > CNT_W'(1));
    assign data_o  = any_o ? row_data[sel*DATA_W +: DATA_W] : '0;

endmodule

// File: rtl/flag_decode_cam.sv
module flag_decode_cam
    import fdc_pkg::*;
#(
    parameter int ROWS   = 32,
    parameter int ID_W   = 8,
    parameter int DATA_W = 32,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ROW_W-1:0]         cfg_row,
    input  logic [ID_W-1:0]          cfg_id,
    input  logic                     cfg_force_flag,
    input  logic                     call_valid,
    input  logic [ID_W-1:0]          call_id,
    input  logic [ROWS-1:0]          row_flag,
    input  logic [ROWS*DATA_W-1:0]   row_data,
    output logic [DATA_W-1:0]        res_bus,
    output logic                     call_hit,
    output logic                     call_miss,
    output logic                     call_reject,
    output logic                     multi_hit,
    output logic                     wb_valid,
    output logic [DATA_W-1:0]        wb_data
);

    localparam logic [ID_W-1:0] RESERVED_ID = '1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } wb_t;

    logic [ROWS-1:0][ID_W-1:0] ids;
    logic [ROWS-1:0]           force_q;
    logic [ROWS-1:0]           hit_vec;
    logic                      lookup_en;
    logic                      any_hit;
    logic                      multi_raw;
    logic [DATA_W-1:0]         sel_data;
    outcome_e                  outcome;
    wb_t                       wb_d, wb_q;

    fdc_id_store #(.ROWS(ROWS), .ID_W(ID_W)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_row        (cfg_row),
        .cfg_id         (cfg_id),
        .cfg_force_flag (cfg_force_flag),
        .ids_o          (ids),
        .force_o        (force_q)
    );

    assign lookup_en = call_valid && (call_id != RESERVED_ID);

    fdc_match #(.ROWS(ROWS), .ID_W(ID_W)) u_match (
        .lookup_en (lookup_en),
        .call_id   (call_id),
        .ids       (ids),
        .force_q   (force_q),
        .row_flag  (row_flag),
        .hit_vec   (hit_vec)
    );

    fdc_prio_sel #(.ROWS(ROWS), .DATA_W(DATA_W)) u_sel (
        .hit_vec  (hit_vec),
        .row_data (row_data),
        .any_o    (any_hit),
        .multi_o  (multi_raw),
        .data_o   (sel_data)
    );

    always_comb begin
        if (!call_valid)          outcome = OUT_IDLE;
        else if (!lookup_en)      outcome = OUT_REJECT;
        else if (any_hit)         outcome = OUT_HIT;
        else                      outcome = OUT_MISS;
    end

    assign call_hit    = (outcome == OUT_HIT);
    assign call_miss   = (outcome == OUT_MISS);
    assign call_reject = (outcome == OUT_REJECT);
    assign multi_hit   = call_hit && multi_raw;
    assign res_bus     = call_hit ? sel_data : '0;

    always_comb begin
        wb_d.vld  = call_hit;
        wb_d.data = call_hit ? sel_data : wb_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign wb_valid = wb_q.vld;
    assign wb_data  = wb_q.data;

endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
    parameter int ID_W   = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_valid,
    input logic [ID_W-1:0]   call_id,
    input logic [DATA_W-1:0] res_bus,
    input logic              call_hit,
    input logic              call_miss,
    input logic              call_reject,
    input logic              multi_hit,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_hit, call_miss, call_reject})); // R5

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !call_valid |-> !call_hit && !call_miss && !call_reject && (res_bus == '0)); // R9

    AST_RESERVED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && (call_id == '1)) |-> call_reject); // R6

    AST_NOHIT_ZERO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !call_hit |-> (res_bus == '0)); // R5

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> call_hit); // R7

    AST_WB_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        call_hit |=> wb_valid && (wb_data == $past(res_bus))); // R8

    AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !call_hit |=> !wb_valid); // R8

endmodule

bind flag_decode_cam fdc_checker #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_valid  (call_valid),
    .call_id     (call_id),
    .res_bus     (res_bus),
    .call_hit    (call_hit),
    .call_miss   (call_miss),
    .call_reject (call_reject),
    .multi_hit   (multi_hit),
    .wb_valid    (wb_valid),
    .wb_data     (wb_data)
);

// File: tb/flag_decode_cam_tb.sv
module flag_decode_cam_tb;

    localparam int ROWS   = 32;
    localparam int ID_W   = 8;
    localparam int DATA_W = 32;
    localparam int ROW_W  = 5;

    // expected outcome codes: 0 hit, 1 miss, 2 reject
    typedef struct packed {
        logic [7:0]  id;
        logic [31:0] flags;
        logic [1:0]  kind;
        logic [4:0]  row;
        logic        multi;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 32'h0000_0002, 2'd0, 5'd1,  1'b0},
        '{8'h10, 32'h0000_0001, 2'd0, 5'd0,  1'b0},
        '{8'h10, 32'h0000_0000, 2'd1, 5'd0,  1'b0},
        '{8'h22, 32'h0000_0000, 2'd0, 5'd5,  1'b0},
        '{8'h33, 32'h0000_0280, 2'd0, 5'd7,  1'b1},
        '{8'h33, 32'h0000_0200, 2'd0, 5'd9,  1'b0},
        '{8'hFE, 32'h8000_0000, 2'd0, 5'd31, 1'b0},
        '{8'hFF, 32'hFFFF_FFFF, 2'd2, 5'd0,  1'b0},
        '{8'h44, 32'hFFFF_FFFF, 2'd1, 5'd0,  1'b0},
        '{8'h10, 32'h0000_0003, 2'd0, 5'd0,  1'b1}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_we = 1'b0;
    logic [ROW_W-1:0]        cfg_row = '0;
    logic [ID_W-1:0]         cfg_id = '0;
    logic                    cfg_force_flag = 1'b0;
    logic                    call_valid = 1'b0;
    logic [ID_W-1:0]         call_id = '0;
    logic [ROWS-1:0]         row_flag = '0;
    logic [ROWS*DATA_W-1:0]  row_data;
    logic [DATA_W-1:0]       res_bus;
    logic                    call_hit, call_miss, call_reject, multi_hit, wb_valid;
    logic [DATA_W-1:0]       wb_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flag_decode_cam #(.ROWS(ROWS), .ID_W(ID_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_id(cfg_id),
        .cfg_force_flag(cfg_force_flag), .call_valid(call_valid), .call_id(call_id),
        .row_flag(row_flag), .row_data(row_data), .res_bus(res_bus), .call_hit(call_hit),
        .call_miss(call_miss), .call_reject(call_reject), .multi_hit(multi_hit),
        .wb_valid(wb_valid), .wb_data(wb_data)
    );

    function automatic logic [31:0] word_of(int r);
        logic [7:0] b;
        b = 8'(r);
        return {b, ~b, 8'h3C, b ^ 8'h96};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(int row, logic [7:0] id, logic frc);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = ROW_W'(row); cfg_id = id; cfg_force_flag = frc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive a call at a falling edge, check the comb outputs, then the writeback
    task automatic do_call(string req, logic [7:0] id, logic [31:0] flags,
                           int kind, int row, logic multi);
        logic [31:0] exp_word;
        exp_word = (kind == 0) ? word_of(row) : 32'h0;
        @(negedge clk);
        call_valid = 1'b1; call_id = id; row_flag = flags;
        #5;
        chk({req, " hit"},    64'(call_hit),    64'(kind == 0));
        chk({req, " miss"},   64'(call_miss),   64'(kind == 1));
        chk({req, " reject"}, 64'(call_reject), 64'(kind == 2));
        chk({req, " bus"},    64'(res_bus),     64'(exp_word));
        chk({req, " multi"},  64'(multi_hit),   64'(multi));
        @(posedge clk);
        #5;
        chk({req, " wb_valid"}, 64'(wb_valid), 64'(kind == 0));
        if (kind == 0) chk({req, " wb_data"}, 64'(wb_data), 64'(exp_word));
        call_valid = 1'b0;
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) row_data[r*DATA_W +: DATA_W] = word_of(r);
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 wb_valid after reset", 64'(wb_valid), 64'd0);
        // R1: nothing configured, so any ID misses with all flags set
        do_call("R1 empty id00", 8'h00, 32'hFFFF_FFFF, 1, 0, 1'b0);
        do_call("R1 empty id10", 8'h10, 32'hFFFF_FFFF, 1, 0, 1'b0);

        cfg(0, 8'h10, 1'b0);
        cfg(1, 8'h10, 1'b0);
        cfg(5, 8'h22, 1'b1);
        cfg(7, 8'h33, 1'b0);
        cfg(9, 8'h33, 1'b0);
        cfg(31, 8'hFE, 1'b0);
        cfg(12, 8'hFF, 1'b1);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            do_call($sformatf("R2/R3/R4/R5/R6/R7/R8 vec%0d", i), VECS[i].id, VECS[i].flags,
                    int'(VECS[i].kind), int'(VECS[i].row), VECS[i].multi);
        end

        // R9: no call, flags that would match
        @(negedge clk);
        call_valid = 1'b0; call_id = 8'h10; row_flag = 32'h3;
        #5;
        chk("R9 idle hit", 64'(call_hit), 64'd0);
        chk("R9 idle miss", 64'(call_miss), 64'd0);
        chk("R9 idle reject", 64'(call_reject), 64'd0);
        chk("R9 idle bus", 64'(res_bus), 64'd0);
        @(posedge clk); #5;
        chk("R9 idle wb_valid", 64'(wb_valid), 64'd0);

        // R10: write row 3 and call its new ID in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = 5'd3; cfg_id = 8'h55; cfg_force_flag = 1'b0;
        call_valid = 1'b1; call_id = 8'h55; row_flag = 32'h8;
        #5;
        chk("R10 same-cycle miss", 64'(call_miss), 64'd1);
        @(negedge clk);
        cfg_we = 1'b0;
        #5;
        chk("R10 next-cycle hit", 64'(call_hit), 64'd1);
        chk("R10 next-cycle bus", 64'(res_bus), 64'(word_of(3)));
        call_valid = 1'b0;

        // R10: rewrite row 7; row 9 keeps its ID and now wins alone
        cfg(7, 8'h66, 1'b0);
        do_call("R10 rewrite row7", 8'h33, 32'h0000_0280, 0, 9, 1'b0);
        do_call("R10 row7 new id", 8'h66, 32'h0000_0080, 0, 7, 1'b0);
        // R10: unconfigure row 9
        cfg(9, 8'hFF, 1'b0);
        do_call("R10 unconfigured", 8'h33, 32'h0000_0280, 1, 0, 1'b0);

        // R1: a second reset clears every row
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_call("R1 after reset row5", 8'h22, 32'hFFFF_FFFF, 1, 0, 1'b0);
        do_call("R1 after reset row0", 8'h10, 32'hFFFF_FFFF, 1, 0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule